// File: doc/BRIEF.md
# Serial port register file with receive queue

This block is the register-side half of a serial port. A host reaches it through a single-cycle, word-addressed register bus: one access per cycle, with reads answered combinationally in the same cycle and all side effects applied at the following clock edge. Received characters come in on a valid/ready stream from a deserializer. A separate strobe reports a line break, which is stored in the queue as a marked entry. A write to the data register hands its low byte to a transmit valid/ready stream.

The block holds a circular receive queue that acts either as a single holding slot or as a 16-deep FIFO, set by a line-control bit. It keeps status flags and a raw/mask/masked interrupt scheme with one interrupt output. It also stores baud, line, control, level-select and DMA settings as plain values and returns a fixed identification byte sequence.

Top module: `uart_regfile`

## Requirements
- R1: After reset the flag register reads 0x90, level select reads 0x12, control reads 0x300, raw and masked status read 0, `irq` is low and `rx_ready` is high.
- R2: Entries leave the queue in arrival order. A data-register read (offset 0x00) returns a 12-bit word: bits 7:0 are the received byte and bits 11:8 are the `rx_err` bits of that character.
- R3: With line-control (offset 0x2C) bit 4 set, the queue holds 16 entries; with it clear, it holds 1. `rx_ready` is low while the queue holds at least its current capacity, and offered characters are not stored then.
- R4: Flag register (offset 0x18) bits: 4 = queue empty, 6 = queue at or above capacity, 7 = no transmit byte pending, 5 = transmit byte pending. Writes to it change nothing.
- R5: A data read from an empty queue changes neither the flags nor the interrupt state.
- R6: A `brk_evt` strobe stores the entry 0x400 (bit 10 set, data bits zero) when there is room. It takes the slot over a character offered in the same cycle, because `rx_ready` is low during the strobe. When the queue is full the break is dropped.
- R7: A write to the data register sets raw status bit 5 and presents the low byte on `tx_data` with `tx_valid` high. The byte holds until a cycle with `tx_ready` high, after which `tx_valid` falls.
- R8: Raw status bit 4 sets when a store brings the count to 1. It clears when a read brings the count to 0.
- R9: Masked status (offset 0x40) equals raw status (0x3C) AND mask (0x38). `irq` is high exactly when masked status is nonzero.
- R10: Writing the clear register (offset 0x44) clears every raw bit written as 1. A raw bit set by an event in the same cycle stays set.
- R11: Registers at 0x20 (8 bits), 0x24 (16 bits), 0x28 (6 bits), 0x2C (8 bits), 0x30 (16 bits), 0x34 (6 bits), 0x38 (11 bits) and 0x48 (3 bits) read back the written value truncated to their width.
- R12: Offsets 0xFE0 + 4k, k = 0..7, return byte k of the identification parameter; the default sequence is 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R13: Undecoded offsets read as 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| rx_valid | input | 1 | Received character offered |
| rx_ready | output | 1 | Queue accepts the offered character |
| rx_byte | input | 8 | Received character |
| rx_err | input | 4 | Error bits stored with the character |
| brk_evt | input | 1 | Line break seen, one cycle |
| tx_valid | output | 1 | Transmit byte pending |
| tx_ready | input | 1 | Serializer takes the pending byte |
| tx_data | output | 8 | Transmit byte |
| irq | output | 1 | Combined interrupt request |

## Verification
The properties assume that there is at most one bus access per cycle, so a clear-register write never meets a data read in the same cycle. They also assume `brk_evt` is a single-cycle pulse. The stimulus drives the bus only through one task that issues exactly one access per call and returns the bus to idle. It raises the break strobe in isolated cycles only. Its heaviest overlap is a break together with an offered character, and a clear write together with a store.

// File: rtl/uart_rf_pkg.sv
// Package: shared constants, register select type and address decode for the
// serial port register file. Assumes byte addresses with word-aligned access.
package uart_rf_pkg;

    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 32;
    localparam int ENTRY_W = 12;
    localparam int NUM_INT = 11;

    // Interrupt and flag bit positions
    localparam int IRQ_RX_BIT  = 4;
    localparam int IRQ_TX_BIT  = 5;
    localparam int FLG_RXE_BIT = 4;
    localparam int FLG_TXF_BIT = 5;
    localparam int FLG_RXF_BIT = 6;
    localparam int FLG_TXE_BIT = 7;
    localparam int LINE_QEN_BIT = 4;

    localparam logic [ENTRY_W-1:0] BREAK_ENTRY = 12'h400;

    // Widths of plain storage registers
    localparam int LPWR_W  = 8;
    localparam int BAUDI_W = 16;
    localparam int BAUDF_W = 6;
    localparam int LINE_W  = 8;
    localparam int CTRL_W  = 16;
    localparam int LVL_W   = 6;
    localparam int DMA_W   = 3;

    localparam logic [CTRL_W-1:0] CTRL_RST = 16'h0300;
    localparam logic [LVL_W-1:0]  LVL_RST  = 6'h12;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_DATA, SEL_FLAG, SEL_LPWR, SEL_BAUDI, SEL_BAUDF,
        SEL_LINE, SEL_CTRL, SEL_LVL, SEL_MASK, SEL_RAW, SEL_MSTAT,
        SEL_CLR, SEL_DMA, SEL_ID
    } reg_sel_e;

    // Map a byte offset to a register select
    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        if (a[ADDR_W-1:5] == 7'h7F) begin
            s = SEL_ID;
        end else begin
            case (a[ADDR_W-1:2])
                10'h000: s = SEL_DATA;
                10'h006: s = SEL_FLAG;
                10'h008: s = SEL_LPWR;
                10'h009: s = SEL_BAUDI;
                10'h00A: s = SEL_BAUDF;
                10'h00B: s = SEL_LINE;
                10'h00C: s = SEL_CTRL;
                10'h00D: s = SEL_LVL;
                10'h00E: s = SEL_MASK;
                10'h00F: s = SEL_RAW;
                10'h010: s = SEL_MSTAT;
                10'h011: s = SEL_CLR;
                10'h012: s = SEL_DMA;
                default: s = SEL_NONE;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/rx_queue.sv
// Circular receive queue with a capacity of DEPTH or 1, picked by q_en.
// Reports stores that hit the trigger level and reads that drop below it.
// Assumes push_req and pop_req are already qualified by the caller's decode.
module rx_queue
    import uart_rf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int TRIG  = 1,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               q_en,
    input  logic               push_req,
    input  logic [ENTRY_W-1:0] push_data,
    input  logic               pop_req,
    output logic [ENTRY_W-1:0] head,
    output logic [CW-1:0]      count,
    output logic               full,
    output logic               push_done,
    output logic               trig_hit,
    output logic               trig_drop
);

    logic [ENTRY_W-1:0] mem [DEPTH];
    logic [PW-1:0]      rd_ptr, wr_ptr;
    logic [CW-1:0]      cap, count_nxt;
    logic               pop_done;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Capacity, handshake and next-count evaluation
    always_comb begin
        cap       = q_en ? CW'(DEPTH) : CW'(1);
        full      = (count >= cap);
        push_done = push_req && !full;
        pop_done  = pop_req && (count != '0);
        count_nxt = count + CW'(push_done) - CW'(pop_done);
        trig_hit  = push_done && (count_nxt == CW'(TRIG));
        trig_drop = pop_done && (count_nxt == CW'(TRIG - 1));
        head      = mem[rd_ptr];
    end

    // Pointer and occupancy registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_done) wr_ptr <= bump(wr_ptr);
            if (pop_done)  rd_ptr <= bump(rd_ptr);
            count <= count_nxt;
        end
    end

    // Entry storage, written on every accepted store
    always_ff @(posedge clk) begin
        if (push_done) mem[wr_ptr] <= push_data;
    end

endmodule

// File: rtl/irq_unit.sv
// Raw interrupt status with write-one-to-clear, the mask register and the
// combined request. A set in the same cycle as a clear wins.
module irq_unit #(
    parameter int NI = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NI-1:0] set_vec,
    input  logic [NI-1:0] clr_vec,
    input  logic          mask_wr,
    input  logic [NI-1:0] mask_wdata,
    output logic [NI-1:0] raw,
    output logic [NI-1:0] mask,
    output logic [NI-1:0] masked,
    output logic          irq
);

    // Raw status update: clear first, then events
    always_ff @(posedge clk) begin
        if (!rst_n) raw <= '0;
        else        raw <= (raw & ~clr_vec) | set_vec;
    end

    // Mask register storage
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (mask_wr) mask <= mask_wdata;
    end

    // Masked view and request line
    always_comb begin
        masked = raw & mask;
        irq    = |masked;
    end

endmodule

// File: rtl/tx_port.sv
// One-byte transmit holding stage on a valid/ready stream. A new load
// replaces any pending byte; a handshake empties the stage.
module tx_port #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [BW-1:0] load_byte,
    input  logic          tx_ready,
    output logic          tx_valid,
    output logic [BW-1:0] tx_data
);

    // Pending flag and data hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else if (load) begin
            tx_valid <= 1'b1;
            tx_data  <= load_byte;
        end else if (tx_valid && tx_ready) begin
            tx_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/uart_regfile.sv
// Register file of a serial port: bus decode, receive queue, flags,
// interrupts, transmit hand-off and identification bytes.
// Assumes one bus access per cycle; reads are combinational, side effects
// land at the next rising edge.
module uart_regfile
    import uart_rf_pkg::*;
#(
    parameter int          DEPTH    = 16,
    parameter logic [63:0] ID_BYTES = 64'hB105_F00D_0014_1011,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [7:0]        rx_byte,
    input  logic [3:0]        rx_err,
    input  logic              brk_evt,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    output logic              irq
);

    reg_sel_e           sel;
    logic               wr_acc, rd_acc;
    logic               data_wr, data_rd, clr_wr;
    logic [LPWR_W-1:0]  lpwr_q;
    logic [BAUDI_W-1:0] baudi_q;
    logic [BAUDF_W-1:0] baudf_q;
    logic [LINE_W-1:0]  line_q;
    logic [CTRL_W-1:0]  ctrl_q;
    logic [LVL_W-1:0]   lvl_q;
    logic [DMA_W-1:0]   dma_q;
    logic               q_en;
    logic               push_req, push_w, q_full, trig_hit, trig_drop;
    logic [ENTRY_W-1:0] push_data, head;
    logic [CW-1:0]      count_w;
    logic [NUM_INT-1:0] set_vec, clr_vec, raw_w, mask_w, masked_w;
    logic [7:0]         flags;
    logic [7:0]         id_byte;

    // Access decode
    always_comb begin
        sel     = decode_addr(bus_addr);
        wr_acc  = bus_sel && bus_write;
        rd_acc  = bus_sel && !bus_write;
        data_wr = wr_acc && (sel == SEL_DATA);
        data_rd = rd_acc && (sel == SEL_DATA);
        clr_wr  = wr_acc && (sel == SEL_CLR);
    end

    // Plain storage registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lpwr_q  <= '0;
            baudi_q <= '0;
            baudf_q <= '0;
            line_q  <= '0;
            ctrl_q  <= CTRL_RST;
            lvl_q   <= LVL_RST;
            dma_q   <= '0;
        end else if (wr_acc) begin
            case (sel)
                SEL_LPWR:  lpwr_q  <= bus_wdata[LPWR_W-1:0];
                SEL_BAUDI: baudi_q <= bus_wdata[BAUDI_W-1:0];
                SEL_BAUDF: baudf_q <= bus_wdata[BAUDF_W-1:0];
                SEL_LINE:  line_q  <= bus_wdata[LINE_W-1:0];
                SEL_CTRL:  ctrl_q  <= bus_wdata[CTRL_W-1:0];
                SEL_LVL:   lvl_q   <= bus_wdata[LVL_W-1:0];
                SEL_DMA:   dma_q   <= bus_wdata[DMA_W-1:0];
                default:   ;
            endcase
        end
    end

    // Receive side: break entry overrides an offered character
    always_comb begin
        q_en      = line_q[LINE_QEN_BIT];
        push_req  = brk_evt || rx_valid;
        push_data = brk_evt ? BREAK_ENTRY : {rx_err, rx_byte};
        rx_ready  = !q_full && !brk_evt;
    end

    rx_queue #(
        .DEPTH (DEPTH),
        .TRIG  (1)
    ) rxq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .q_en      (q_en),
        .push_req  (push_req),
        .push_data (push_data),
        .pop_req   (data_rd),
        .head      (head),
        .count     (count_w),
        .full      (q_full),
        .push_done (push_w),
        .trig_hit  (trig_hit),
        .trig_drop (trig_drop)
    );

    // Interrupt event and clear vectors
    always_comb begin
        set_vec = '0;
        set_vec[IRQ_RX_BIT] = trig_hit;
        set_vec[IRQ_TX_BIT] = data_wr;
        clr_vec = clr_wr ? bus_wdata[NUM_INT-1:0] : '0;
        clr_vec[IRQ_RX_BIT] = clr_vec[IRQ_RX_BIT] | trig_drop;
    end

    irq_unit #(
        .NI (NUM_INT)
    ) irq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_vec    (set_vec),
        .clr_vec    (clr_vec),
        .mask_wr    (wr_acc && (sel == SEL_MASK)),
        .mask_wdata (bus_wdata[NUM_INT-1:0]),
        .raw        (raw_w),
        .mask       (mask_w),
        .masked     (masked_w),
        .irq        (irq)
    );

    tx_port #(
        .BW (8)
    ) tx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (data_wr),
        .load_byte (bus_wdata[7:0]),
        .tx_ready  (tx_ready),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data)
    );

    // Status flag assembly
    always_comb begin
        flags = '0;
        flags[FLG_RXE_BIT] = (count_w == '0);
        flags[FLG_RXF_BIT] = q_full;
        flags[FLG_TXE_BIT] = !tx_valid;
        flags[FLG_TXF_BIT] = tx_valid;
        id_byte = ID_BYTES[{bus_addr[4:2], 3'b000} +: 8];
    end

    // Read data multiplexer
    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_DATA:  bus_rdata[ENTRY_W-1:0] = head;
            SEL_FLAG:  bus_rdata[7:0]         = flags;
            SEL_LPWR:  bus_rdata[LPWR_W-1:0]  = lpwr_q;
            SEL_BAUDI: bus_rdata[BAUDI_W-1:0] = baudi_q;
            SEL_BAUDF: bus_rdata[BAUDF_W-1:0] = baudf_q;
            SEL_LINE:  bus_rdata[LINE_W-1:0]  = line_q;
            SEL_CTRL:  bus_rdata[CTRL_W-1:0]  = ctrl_q;
            SEL_LVL:   bus_rdata[LVL_W-1:0]   = lvl_q;
            SEL_MASK:  bus_rdata[NUM_INT-1:0] = mask_w;
            SEL_RAW:   bus_rdata[NUM_INT-1:0] = raw_w;
            SEL_MSTAT: bus_rdata[NUM_INT-1:0] = masked_w;
            SEL_DMA:   bus_rdata[DMA_W-1:0]   = dma_q;
            SEL_ID:    bus_rdata[7:0]         = id_byte;
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/uart_regfile_chk.sv
// Property checker for uart_regfile, attached by bind below.
// Assumes one bus access per cycle and single-cycle break strobes.
module uart_regfile_chk #(
    parameter int DEPTH = 16,
    parameter int NI    = 11,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] count,
    input logic          q_en,
    input logic          push,
    input logic [NI-1:0] raw,
    input logic [NI-1:0] mask,
    input logic          irq,
    input logic          tx_valid,
    input logic          tx_ready,
    input logic [7:0]    tx_data,
    input logic          data_wr
);

    // R3
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R3
    single_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!q_en && count != '0) |=> (count <= $past(count)));

    // R4
    empty_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(count) == '0 && !$past(push)) |-> (count == '0));

    // R8
    rx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(count) == CW'(1) && count == '0) |-> !raw[4]);

    // R7
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !data_wr) |=> (tx_valid && $stable(tx_data)));

    // R7
    tx_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> raw[5]);

    // R9
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((raw & mask) != '0));

endmodule

bind uart_regfile uart_regfile_chk #(
    .DEPTH (DEPTH),
    .NI    (uart_rf_pkg::NUM_INT)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .count    (count_w),
    .q_en     (q_en),
    .push     (push_w),
    .raw      (raw_w),
    .mask     (mask_w),
    .irq      (irq),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_data  (tx_data),
    .data_wr  (data_wr)
);

// File: tb/uart_regfile_tb_top.sv
// Bench: behavioural reference model (queue plus integers) stepped on every
// clock and compared against the design's ports.
module uart_regfile_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_sel, bus_write;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        rx_valid, rx_ready, brk_evt;
    logic [7:0]  rx_byte;
    logic [3:0]  rx_err;
    logic        tx_valid, tx_ready, irq;
    logic [7:0]  tx_data;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // Reference model state
    int q[$];
    int m_lpwr, m_bi, m_bf, m_line, m_ctrl, m_lvl, m_dma, m_mask, m_raw, m_txd;
    bit m_txv;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_regfile dut_i (
        .clk (clk), .rst_n (rst_n),
        .bus_sel (bus_sel), .bus_write (bus_write), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .rx_valid (rx_valid), .rx_ready (rx_ready), .rx_byte (rx_byte),
        .rx_err (rx_err), .brk_evt (brk_evt),
        .tx_valid (tx_valid), .tx_ready (tx_ready), .tx_data (tx_data),
        .irq (irq)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic int cap();
        return m_line[4] ? 16 : 1;
    endfunction

    function automatic int m_flags();
        int f = m_txv ? 32'h20 : 32'h80;
        if (q.size() == 0) f |= 32'h10;
        if (q.size() >= cap()) f |= 32'h40;
        return f;
    endfunction

    function automatic int id_of(input int k);
        case (k)
            0: return 32'h11; 1: return 32'h10; 2: return 32'h14; 3: return 32'h00;
            4: return 32'h0D; 5: return 32'hF0; 6: return 32'h05; default: return 32'hB1;
        endcase
    endfunction

    // Expected read value; -1 means unspecified (empty queue data)
    function automatic int m_read(input int a);
        if (a >= 12'hFE0) return id_of((a - 12'hFE0) >> 2);
        case (a)
            12'h000: return (q.size() > 0) ? q[0] : -1;
            12'h018: return m_flags();
            12'h020: return m_lpwr;
            12'h024: return m_bi;
            12'h028: return m_bf;
            12'h02C: return m_line;
            12'h030: return m_ctrl;
            12'h034: return m_lvl;
            12'h038: return m_mask;
            12'h03C: return m_raw;
            12'h040: return m_raw & m_mask;
            12'h048: return m_dma;
            default: return 0;
        endcase
    endfunction

    task automatic m_reset();
        q.delete();
        m_lpwr = 0; m_bi = 0; m_bf = 0; m_line = 0; m_ctrl = 32'h300;
        m_lvl = 32'h12; m_dma = 0; m_mask = 0; m_raw = 0; m_txv = 0; m_txd = 0;
    endtask

    // Advance the model by one clock using the inputs held at the edge
    task automatic m_clock();
        bit full = (q.size() >= cap());
        bit push = 0;
        bit pop = 0;
        int pv = 0;
        int a = int'(bus_addr);
        int w = int'(bus_wdata);
        if (brk_evt && !full) begin push = 1; pv = 32'h400; end
        else if (rx_valid && !full) begin push = 1; pv = {20'd0, rx_err, rx_byte}; end
        if (bus_sel && !bus_write && a == 0 && q.size() > 0) begin
            void'(q.pop_front()); pop = 1;
        end
        if (push) q.push_back(pv);
        if (pop && q.size() == 0) m_raw &= ~32'h10;
        if (m_txv && tx_ready) m_txv = 0;
        if (bus_sel && bus_write) begin
            case (a)
                12'h000: begin m_txv = 1; m_txd = w & 32'hFF; m_raw |= 32'h20; end
                12'h020: m_lpwr = w & 32'hFF;
                12'h024: m_bi   = w & 32'hFFFF;
                12'h028: m_bf   = w & 32'h3F;
                12'h02C: m_line = w & 32'hFF;
                12'h030: m_ctrl = w & 32'hFFFF;
                12'h034: m_lvl  = w & 32'h3F;
                12'h038: m_mask = w & 32'h7FF;
                12'h044: m_raw &= ~(w & 32'h7FF);
                12'h048: m_dma  = w & 32'h7;
                default: ;
            endcase
        end
        if (push && q.size() == 1) m_raw |= 32'h10;
    endtask

    task automatic idle();
        bus_sel = 0; bus_write = 0; bus_addr = '0; bus_wdata = '0;
        rx_valid = 0; rx_byte = '0; rx_err = '0; brk_evt = 0;
    endtask

    // One clock: inputs already driven after a falling edge
    task automatic step(input string req);
        int e;
        #1;
        chk(req, "rx_ready", int'(rx_ready), int'((q.size() < cap()) && !brk_evt));
        if (bus_sel && !bus_write) begin
            e = m_read(int'(bus_addr));
            if (e >= 0) chk(req, $sformatf("rdata@%0h", bus_addr), int'(bus_rdata), e);
        end
        @(posedge clk);
        m_clock();
        @(negedge clk);
        chk(req, "irq", int'(irq), int'((m_raw & m_mask) != 0));
        chk(req, "tx_valid", int'(tx_valid), int'(m_txv));
        if (m_txv) chk(req, "tx_data", int'(tx_data), m_txd);
        idle();
    endtask

    task automatic rd(input int a, input string req);
        bus_sel = 1; bus_write = 0; bus_addr = a[11:0];
        step(req);
    endtask

    task automatic wr(input int a, input int d, input string req);
        bus_sel = 1; bus_write = 1; bus_addr = a[11:0]; bus_wdata = d;
        step(req);
    endtask

    task automatic rx(input int b, input int err, input string req);
        rx_valid = 1; rx_byte = b[7:0]; rx_err = err[3:0];
        step(req);
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        idle();
        tx_ready = 1;
        rst_n = 0;
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset values (explicit literals as well as model)
        #1;
        chk("R1", "irq", int'(irq), 0);
        chk("R1", "rx_ready", int'(rx_ready), 1);
        bus_sel = 1; bus_addr = 12'h018; #1;
        chk("R1", "flags", int'(bus_rdata), 32'h90);
        bus_addr = 12'h034; #1; chk("R1", "level", int'(bus_rdata), 32'h12);
        bus_addr = 12'h030; #1; chk("R1", "ctrl", int'(bus_rdata), 32'h300);
        bus_addr = 12'h03C; #1; chk("R1", "raw", int'(bus_rdata), 0);
        idle();
        rd(12'h040, "R1");

        // R13 undecoded offsets
        wr(12'h004, 32'hFFFF_FFFF, "R13");
        rd(12'h004, "R13");
        rd(12'h04C, "R13");
        rd(12'h018, "R13");
        // R4 flag register writes ignored
        wr(12'h018, 32'h0000_00FF, "R4");
        rd(12'h018, "R4");

        // R11 plain storage truncation
        wr(12'h020, 32'h1AB, "R11");   rd(12'h020, "R11");
        wr(12'h024, 32'h12345, "R11"); rd(12'h024, "R11");
        wr(12'h028, 32'hFF, "R11");    rd(12'h028, "R11");
        wr(12'h030, 32'h1ABCD, "R11"); rd(12'h030, "R11");
        wr(12'h034, 32'h7F, "R11");    rd(12'h034, "R11");
        wr(12'h048, 32'hF, "R11");     rd(12'h048, "R11");

        // R12 identification bytes
        for (int k = 0; k < 8; k++) rd(12'hFE0 + 4 * k, "R12");

        // R3 single-slot mode, R8 and R9 interrupt
        wr(12'h02C, 32'h0, "R3");
        wr(12'h038, 32'h7FF, "R11");
        rd(12'h038, "R11");
        rx(32'h41, 2, "R3");
        rx(32'h42, 0, "R3");          // refused: rx_ready low
        rd(12'h018, "R3");
        rd(12'h03C, "R8");
        rd(12'h040, "R9");
        rd(12'h000, "R2");            // returns 0x241
        rd(12'h03C, "R8");
        rd(12'h018, "R4");
        // R5 read of empty queue
        rd(12'h000, "R5");
        rd(12'h018, "R5");
        rd(12'h03C, "R5");

        // R6 break when full is dropped
        rx(32'h55, 0, "R6");
        brk_evt = 1; step("R6");
        rd(12'h000, "R6");
        rd(12'h018, "R6");

        // R3 deep mode, R2 ordering with error bits
        wr(12'h02C, 32'h10, "R3");
        for (int i = 0; i < 16; i++) rx(32'h30 + i, i, "R2");
        rd(12'h018, "R3");
        rx(32'hEE, 0, "R3");          // refused
        for (int i = 0; i < 16; i++) rd(12'h000, "R2");
        rd(12'h018, "R4");

        // R6 break alone and break against a character
        brk_evt = 1; step("R6");
        brk_evt = 1; rx_valid = 1; rx_byte = 8'h77; step("R6");
        rx(32'h78, 1, "R6");
        rd(12'h000, "R6");
        rd(12'h000, "R6");
        rd(12'h000, "R6");

        // R7 transmit hand-off with a stalled receiver
        wr(12'h044, 32'h7FF, "R10");
        rd(12'h03C, "R10");
        wr(12'h038, 32'h20, "R9");
        tx_ready = 0;
        wr(12'h000, 32'h1A5, "R7");
        rd(12'h018, "R7");
        rd(12'h03C, "R7");
        rd(12'h040, "R9");
        tx_ready = 1;
        rd(12'h018, "R7");
        rd(12'h018, "R4");

        // R10 clear vs simultaneous store: set wins
        wr(12'h038, 32'h30, "R9");
        bus_sel = 1; bus_write = 1; bus_addr = 12'h044; bus_wdata = 32'h30;
        rx_valid = 1; rx_byte = 8'h99; step("R10");
        rd(12'h03C, "R10");
        rd(12'h040, "R9");
        wr(12'h044, 32'h10, "R10");
        rd(12'h03C, "R10");
        wr(12'h038, 32'h0, "R9");
        rd(12'h040, "R9");
        rd(12'h000, "R2");

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule